// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Input Shaping

The controller gathers fifteen interrupt sources into one pending register and hands the processor the number of the most urgent enabled request as a 4-bit level, where 0 means no request. Five sources are external pins. Each pin passes through a two-flop synchronizer and then a shaping stage that software sets per pin: active-high or active-low, and level or edge sensitive. The other ten sources are single-cycle event pulses from on-chip timers, serial ports, DMA, memory-correction logic, error collection and the watchdog.

Software reaches the controller through a plain register port with a write strobe, a 3-bit select, write data and a read-data output that is combinational on the select. Through this port it loads the pending register directly, enables or disables each source, clears pending bits by writing ones and raises pending bits by writing ones. When the processor takes an interrupt it returns the level with a one-cycle strobe. The matching pending bit then drops by itself. If that level belongs to an external pin, a one-cycle acknowledge pulse is driven out. All interfaces are control pins, so there is no back-pressure anywhere.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the shape, pending and enable registers read 0, `irq_level` is 0 and `ext_ack` is 0.
- R2: Source levels are fixed: watchdog 15, pin 4 = 14, real-time timer 13, general timer 12, pin 3 = 11, pin 2 = 10, DMA timeout 9, DMA access error 8, serial error 7, correctable memory error 6, serial B 5, serial A 4, pin 1 = 3, pin 0 = 2, masked hardware errors 1. `int_evt` bit k maps to levels {1,4,5,6,7,8,9,12,13,15} for k = 0..9. `irq_level` is the highest level whose pending bit is set and whose source is enabled.
- R3: A pending bit whose enable bit (select 2, bit n for level n, 1 = enabled) is 0 does not drive `irq_level`, but it still reads back as set at select 1.
- R4: Level 15 drives `irq_level` whenever it is pending, whatever its enable bit holds.
- R5: An acknowledge strobe with level n clears pending bit n at the next rising edge.
- R6: An acknowledge of level 2, 3, 10, 11 or 14 makes `ext_ack` high for exactly the one cycle after the strobe. An acknowledge of any other level leaves it low.
- R7: Shape bit p (select 0, bits 4..0) set to 1 makes pin p active-low. When it is 0 the pin is active-high.
- R8: Shape bit 5+p set to 1 makes pin p edge sensitive, so it sets pending only on entering the active state. When it is 0 the pin is level sensitive and sets pending in every cycle it is active, so an acknowledge does not remove a request while the pin stays active.
- R9: Writing select 3 clears every pending bit written as 1 and leaves the others unchanged.
- R10: Writing select 4 sets every pending bit written as 1.
- R11: Writing select 1 loads the pending register with the write data, except that bit 0 always reads 0.
- R12: A pin change becomes visible in the pending register at the third rising edge after it and not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 5 | Asynchronous external interrupt pins |
| int_evt | input | 10 | On-chip event pulses, one bit per internal source |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 shape, 1 pending, 2 enable, 3 clear, 4 force |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for the selected register (clear and force read 0) |
| ack_stb | input | 1 | One-cycle acknowledge strobe from the processor |
| ack_lvl | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Highest enabled pending level, 0 if none |
| ext_ack | output | 1 | One-cycle acknowledge pulse for external sources |

## Verification
The checker assumes that `ack_stb` lasts a single cycle and carries the level the processor took, and that an acknowledge strobe is never issued in two consecutive cycles. The sequences keep to this by returning each strobe to low before the next operation. The asynchronous pins are driven only one time unit after a rising edge, so synchronizer latency can be counted in whole edges. Internal events are one-cycle pulses, as the block expects from its on-chip neighbours.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LVLW   = 4;
  localparam int NLVL   = 1 << LVLW;
  localparam int NEXT   = 5;
  localparam int NINT   = 10;
  localparam int DW     = NLVL;
  localparam int SHAPEW = 2 * NEXT;
  localparam int NMI_LVL = NLVL - 1;

  typedef enum logic [2:0] {
    SEL_SHAPE = 3'd0,
    SEL_PEND  = 3'd1,
    SEL_MASK  = 3'd2,
    SEL_CLR   = 3'd3,
    SEL_FORCE = 3'd4
  } reg_sel_e;

  function automatic int ext_level(input int k);
    case (k)
      0: return 2;
      1: return 3;
      2: return 10;
      3: return 11;
      default: return 14;
    endcase
  endfunction

  function automatic int int_level(input int k);
    case (k)
      0: return 1;
      1: return 4;
      2: return 5;
      3: return 6;
      4: return 7;
      5: return 8;
      6: return 9;
      7: return 12;
      8: return 13;
      default: return 15;
    endcase
  endfunction

  function automatic logic is_ext_level(input logic [LVLW-1:0] lvl);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < NEXT; k++)
      if (int'(lvl) == ext_level(k)) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/prio_irq_shaper.sv
module prio_irq_shaper #(
  parameter int NPIN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin,
  input  logic [NPIN-1:0] act_low,
  input  logic [NPIN-1:0] edge_mode,
  output logic [NPIN-1:0] hit
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic s1, s2, s3;
    logic act_now, act_prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= pin[p];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign act_now  = s2 ^ act_low[p];
    assign act_prev = s3 ^ act_low[p];
    assign hit[p]   = edge_mode[p] ? (act_now & ~act_prev) : act_now;
  end
endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [2:0]      sel,
  input  logic [DW-1:0]   wdata,
  input  logic [NEXT-1:0] ext_hit,
  input  logic [NINT-1:0] int_evt,
  input  logic            ack_stb,
  input  logic [LVLW-1:0] ack_lvl,
  output logic [DW-1:0]   pend,
  output logic [DW-1:0]   mask,
  output logic [DW-1:0]   shape
);
  localparam logic [DW-1:0] SHAPE_BITS = DW'((1 << SHAPEW) - 1);

  reg_sel_e        rsel;
  logic [DW-1:0]   set_v, clr_v, frc_v, pend_d;

  assign rsel = reg_sel_e'(sel);

  always_comb begin
    set_v = '0;
    for (int k = 0; k < NEXT; k++)
      set_v[ext_level(k)] = set_v[ext_level(k)] | ext_hit[k];
    for (int k = 0; k < NINT; k++)
      set_v[int_level(k)] = set_v[int_level(k)] | int_evt[k];
    clr_v = (wr && rsel == SEL_CLR) ? wdata : '0;
    if (ack_stb) clr_v[ack_lvl] = 1'b1;
    frc_v = (wr && rsel == SEL_FORCE) ? wdata : '0;
    if (wr && rsel == SEL_PEND) pend_d = wdata;
    else                        pend_d = (pend & ~clr_v) | set_v | frc_v;
    pend_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      mask  <= '0;
      shape <= '0;
    end else begin
      pend <= pend_d;
      if (wr && rsel == SEL_MASK)  mask  <= wdata & ~DW'(1);
      if (wr && rsel == SEL_SHAPE) shape <= wdata & SHAPE_BITS;
    end
  end
endmodule

// File: rtl/prio_irq_encode.sv
module prio_irq_encode
  import prio_irq_pkg::*;
(
  input  logic [DW-1:0]   pend,
  input  logic [DW-1:0]   mask,
  output logic [LVLW-1:0] level
);
  logic [DW-1:0] live;
  always_comb begin
    live = pend & mask;
    live[NMI_LVL] = pend[NMI_LVL];
    live[0] = 1'b0;
    level = '0;
    for (int i = 1; i < NLVL; i++)
      if (live[i]) level = LVLW'(i);
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      ext_pin,
  input  logic [9:0]      int_evt,
  input  logic            reg_wr,
  input  logic [2:0]      reg_sel,
  input  logic [15:0]     reg_wdata,
  output logic [15:0]     reg_rdata,
  input  logic            ack_stb,
  input  logic [3:0]      ack_lvl,
  output logic [3:0]      irq_level,
  output logic            ext_ack
);
  logic [NEXT-1:0] ext_hit;
  logic [DW-1:0]   pend_q, mask_q, shape_q;

  prio_irq_shaper #(.NPIN(NEXT)) u_shape (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin),
    .act_low(shape_q[NEXT-1:0]), .edge_mode(shape_q[SHAPEW-1:NEXT]),
    .hit(ext_hit)
  );

  prio_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .ext_hit(ext_hit), .int_evt(int_evt), .ack_stb(ack_stb), .ack_lvl(ack_lvl),
    .pend(pend_q), .mask(mask_q), .shape(shape_q)
  );

  prio_irq_encode u_enc (.pend(pend_q), .mask(mask_q), .level(irq_level));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_ack <= 1'b0;
    else        ext_ack <= ack_stb && is_ext_level(ack_lvl);
  end

  always_comb begin
    case (reg_sel_e'(reg_sel))
      SEL_SHAPE: reg_rdata = shape_q;
      SEL_PEND:  reg_rdata = pend_q;
      SEL_MASK:  reg_rdata = mask_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ack_stb,
  input logic [3:0]  irq_level,
  input logic        ext_ack,
  input logic [15:0] pend,
  input logic [15:0] mask
);
  AST_NMI_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    pend[15] |-> irq_level == 4'd15); // R4
  AST_LEVEL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level != 4'd0 |-> pend[irq_level]); // R2
  AST_LEVEL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != 4'd0 && irq_level != 4'd15) |-> mask[irq_level]); // R3
  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |-> $past(ack_stb)); // R6
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ack && !ack_stb) |=> !ext_ack); // R6
  AST_BIT0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[0]); // R11
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_stb(ack_stb), .irq_level(irq_level),
  .ext_ack(ext_ack), .pend(pend_q), .mask(mask_q)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ext_pin = '0;
  logic [9:0]  int_evt = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ack_stb = 1'b0;
  logic [3:0]  ack_lvl = '0;
  logic [3:0]  irq_level;
  logic        ext_ack;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { int kind; int sel; int exp; string req; } item_t;
  item_t sb[$];

  prio_irq_ctrl uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops expected items and compares against the outputs
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      int act;
      it = sb.pop_front();
      case (it.kind)
        0: act = int'(irq_level);
        1: act = int'(reg_rdata);
        default: act = int'(ext_ack);
      endcase
      n_run++;
      if (act != it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input int exp, input string req, input int sel = 0);
    item_t it;
    if (kind == 1) reg_sel = 3'(sel);
    it.kind = kind; it.sel = sel; it.exp = exp; it.req = req;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int sel, input int data);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_sel = 3'(sel); reg_wdata = 16'(data);
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input int k);
    @(posedge clk); #1;
    int_evt[k] = 1'b1;
    @(posedge clk); #1;
    int_evt[k] = 1'b0;
  endtask

  task automatic ack(input int lvl, input int exp_ack, input string req);
    @(posedge clk); #1;
    ack_stb = 1'b1; ack_lvl = 4'(lvl);
    @(posedge clk); #1;
    ack_stb = 1'b0;
    push(2, exp_ack, req);
    step(1);
    push(2, 0, req);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    push(1, 0, "R1", 0);
    push(1, 0, "R1", 1);
    push(1, 0, "R1", 2);
    push(0, 0, "R1");
    push(2, 0, "R1");

    // serial A (k1 -> 4) and general timer (k7 -> 12)
    pulse(1); pulse(7); step(1);
    push(1, 'h1010, "R3", 1);
    push(0, 0, "R3");
    wr(2, 'hFFFE); step(1);
    push(0, 12, "R2");
    wr(2, 'hEFFE); step(1);
    push(0, 4, "R3");
    wr(2, 'hFFFE);

    // watchdog k9 -> 15, non-maskable
    pulse(9); step(1);
    push(0, 15, "R2");
    wr(2, 'h0000); step(1);
    push(0, 15, "R4");
    wr(2, 'hFFFE);
    ack(15, 0, "R6");
    push(1, 'h1010, "R5", 1);
    push(0, 12, "R5");

    // clear and force
    wr(3, 'h1000); step(1);
    push(1, 'h0010, "R9", 1);
    wr(4, 'h0400); step(1);
    push(1, 'h0410, "R10", 1);
    push(0, 10, "R10");
    ack(10, 1, "R6");
    push(1, 'h0010, "R5", 1);

    // direct pending load
    wr(1, 'h0007); step(1);
    push(1, 'h0006, "R11", 1);
    push(0, 2, "R11");
    wr(1, 0);

    // pin 0, level mode, active high: latency
    @(posedge clk); #1; ext_pin[0] = 1'b1;
    step(2);
    push(1, 'h0000, "R12", 1);
    step(1);
    push(1, 'h0004, "R12", 1);
    ack(2, 1, "R8");
    push(1, 'h0004, "R8", 1);
    ext_pin[0] = 1'b0; step(4);
    ack(2, 1, "R6");
    push(1, 'h0000, "R8", 1);

    // pin 1 edge mode
    wr(0, 'h0040);
    push(1, 'h0040, "R8", 0);
    ext_pin[1] = 1'b1; step(4);
    push(1, 'h0008, "R8", 1);
    ack(3, 1, "R8");
    step(3);
    push(1, 'h0000, "R8", 1);
    ext_pin[1] = 1'b0; step(4);

    // pin 4 active low, level mode
    wr(0, 'h0010); step(4);
    push(1, 'h4000, "R7", 1);
    push(0, 14, "R7");
    ext_pin[4] = 1'b1; step(3);
    wr(1, 0); step(3);
    push(1, 'h0000, "R7", 1);

    done = 1;
    report();
    $finish;
  end
endmodule